// File: doc/BRIEF.md
# Watchdog Sleep-Mode Detector

This block sits beside a windowed watchdog and notices when the host processor has stopped servicing it altogether, for instance because the host has gone into standby. Every time the watchdog gives up waiting for a clear and emits its reset pulse, it sends this block a one-cycle timeout strobe. When three such strobes arrive in a row with no activity on the clear line in between, the block raises a sleep flag. That flag selects a slow time base for the supervisor. While the flag is up, the block produces its own sparse heartbeat reset: a short pulse once per long period.

The block leaves sleep on any change of level on the clear input, whether rising or falling. It also leaves sleep when the power-good level drops. On leaving sleep it emits a one-cycle wake strobe. The companion watchdog uses that strobe to restart from the beginning of a closed window, with its enable output held inactive until three fresh in-window services have been seen. The clear input is expected to be synchronous to `clk`.

All durations are counted in cycles of `clk`. The parameters `MISS_LIMIT`, `HB_PERIOD` and `HB_PULSE` set the number of strobes needed to enter sleep, the heartbeat period and the heartbeat pulse width.

Top module: `wsd_sleep_detect`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `sleep_o`, `hb_rst_o` and `wake_o` are all 0.
- R2: `sleep_o` rises one cycle after the clock edge that takes the MISS_LIMIT-th consecutive `wd_timeout` strobe (3 by default). Fewer consecutive strobes leave it at 0.
- R3: A level change on `clr_in` restarts the missed-strobe count from zero. After such a change, a further MISS_LIMIT strobes are needed to enter sleep.
- R4: While asleep, `hb_rst_o` follows a fixed pattern. Index the cycles from 0, where cycle 0 is the first cycle with `sleep_o` = 1. The pulse is high in a cycle exactly when (index mod HB_PERIOD) >= HB_PERIOD-HB_PULSE. While awake, `hb_rst_o` is 0.
- R5: A rising level change on `clr_in` during sleep clears `sleep_o` one clock edge later.
- R6: A falling level change on `clr_in` during sleep clears `sleep_o` one clock edge later.
- R7: `pwr_good` = 0 clears `sleep_o` and the missed-strobe count at the next edge. Strobes that arrive while `pwr_good` is 0 are not counted.
- R8: `wake_o` is 1 for exactly one cycle, the cycle right after sleep is left. A clear change while awake does not raise it.
- R9: When a `clr_in` change and the strobe that would complete the count arrive in the same cycle, the change wins: sleep is not entered and the count returns to zero.
- R10: Timeout strobes that arrive during sleep do not disturb `sleep_o` or the heartbeat pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_in | input | 1 | Watchdog clear line from the host |
| wd_timeout | input | 1 | One-cycle strobe for each missed-clear reset pulse of the watchdog |
| pwr_good | input | 1 | Supply valid level, active high |
| sleep_o | output | 1 | Sleep flag, selects the slow time base when 1 |
| hb_rst_o | output | 1 | Heartbeat reset pulse emitted during sleep, active high |
| wake_o | output | 1 | One-cycle strobe when sleep is left |

## Verification
Every input event is captured by a single register stage. After the clock edge that takes a strobe, a clear change or a power-good drop, `sleep_o` and `wake_o` are therefore due at once. The bench drives inputs just after a falling edge, lets exactly one rising edge pass, and samples at the following falling edge. The heartbeat is combinational from the phase counter, and the phase is zero in the first sleep cycle. The bench therefore indexes its expected pulse pattern from the first sample that shows `sleep_o` = 1, and compares every cycle over several periods.

// File: rtl/wsd_pkg.sv
package wsd_pkg;

    typedef enum logic {
        MODE_RUN   = 1'b0,
        MODE_SLEEP = 1'b1
    } base_mode_e;

    typedef struct packed {
        logic clr_edge;
        logic timeout;
        logic power_ok;
    } wsd_evt_t;

    function automatic logic leave_sleep(wsd_evt_t e);
        return e.clr_edge || !e.power_ok;
    endfunction

endpackage

// File: rtl/wsd_edge.sv
module wsd_edge (
    input  logic clk,
    input  logic rst,
    input  logic clr_in,
    output logic clr_edge
);
    logic clr_q;

    always_ff @(posedge clk) begin
        clr_q <= clr_in;
    end

    assign clr_edge = !rst && (clr_in != clr_q);

    // R5 R6: a change of level must be flagged whatever its direction
    a_r5_any_change: assert property (@(posedge clk) disable iff (rst)
        (clr_in != $past(clr_in)) |-> clr_edge);
endmodule

// File: rtl/wsd_miss_cnt.sv
module wsd_miss_cnt
    import wsd_pkg::*;
#(
    parameter int MISS_LIMIT = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  wsd_evt_t                        evt,
    output logic [$clog2(MISS_LIMIT+1)-1:0] cnt,
    output logic                            hit
);
    localparam int CW = $clog2(MISS_LIMIT+1);
    localparam logic [CW-1:0] LAST = CW'(MISS_LIMIT - 1);
    localparam logic [CW-1:0] TOP  = CW'(MISS_LIMIT);

    always_ff @(posedge clk) begin
        if (rst || leave_sleep(evt))
            cnt <= '0;
        else if (evt.timeout && cnt != TOP)
            cnt <= cnt + 1'b1;
    end

    assign hit = evt.timeout && (cnt == LAST) && !leave_sleep(evt);

    a_r3_edge_zeroes: assert property (@(posedge clk) disable iff (rst)
        evt.clr_edge |=> (cnt == '0));
    a_r2_saturates: assert property (@(posedge clk) disable iff (rst)
        (cnt == TOP) |=> (cnt == TOP) || (cnt == '0));
endmodule

// File: rtl/wsd_beat.sv
module wsd_beat #(
    parameter int HB_PERIOD = 32000,
    parameter int HB_PULSE  = 96
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic hb
);
    localparam int PW = (HB_PERIOD > 1) ? $clog2(HB_PERIOD) : 1;
    localparam logic [PW-1:0] WRAP  = PW'(HB_PERIOD - 1);
    localparam logic [PW-1:0] START = PW'(HB_PERIOD - HB_PULSE);

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || !active)
            phase <= '0;
        else if (phase == WRAP)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    assign hb = active && (phase >= START);

    a_r4_quiet_awake: assert property (@(posedge clk) disable iff (rst)
        !active |-> !hb);
    a_r4_phase_bound: assert property (@(posedge clk) disable iff (rst)
        phase <= WRAP);
endmodule

// File: rtl/wsd_sleep_detect.sv
module wsd_sleep_detect
    import wsd_pkg::*;
#(
    parameter int MISS_LIMIT = 3,
    parameter int HB_PERIOD  = 32000,
    parameter int HB_PULSE   = 96
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_in,
    input  logic wd_timeout,
    input  logic pwr_good,
    output logic sleep_o,
    output logic hb_rst_o,
    output logic wake_o
);
    localparam int CW = $clog2(MISS_LIMIT+1);

    wsd_evt_t   evt;
    logic       clr_edge;
    logic       hit;
    logic [CW-1:0] miss;
    base_mode_e mode_q;
    logic       wake_q;

    wsd_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .clr_in   (clr_in),
        .clr_edge (clr_edge)
    );

    always_comb begin
        evt.clr_edge = clr_edge;
        evt.timeout  = wd_timeout;
        evt.power_ok = pwr_good;
    end

    wsd_miss_cnt #(.MISS_LIMIT(MISS_LIMIT)) u_miss (
        .clk (clk),
        .rst (rst),
        .evt (evt),
        .cnt (miss),
        .hit (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RUN;
            wake_q <= 1'b0;
        end else begin
            wake_q <= (mode_q == MODE_SLEEP) && leave_sleep(evt);
            if (leave_sleep(evt))
                mode_q <= MODE_RUN;
            else if (hit)
                mode_q <= MODE_SLEEP;
        end
    end

    wsd_beat #(.HB_PERIOD(HB_PERIOD), .HB_PULSE(HB_PULSE)) u_beat (
        .clk    (clk),
        .rst    (rst),
        .active (mode_q == MODE_SLEEP),
        .hb     (hb_rst_o)
    );

    assign sleep_o = (mode_q == MODE_SLEEP);
    assign wake_o  = wake_q;

    a_r2_enter: assert property (@(posedge clk) disable iff (rst)
        (!sleep_o && wd_timeout && pwr_good && !clr_edge
         && miss == CW'(MISS_LIMIT - 1)) |=> sleep_o);
    a_r5_edge_exits: assert property (@(posedge clk) disable iff (rst)
        clr_edge |=> !sleep_o);
    a_r7_power_drop: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> (!sleep_o && miss == '0));
    a_r8_wake_after_sleep: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> ($past(sleep_o) && !sleep_o));
    a_r10_hold_in_sleep: assert property (@(posedge clk) disable iff (rst)
        (sleep_o && pwr_good && !clr_edge) |=> sleep_o);
endmodule

// File: tb/sim_wsd_sleep_detect.sv
`timescale 1ns/1ps
module sim_wsd_sleep_detect;
    localparam int LIM = 3;
    localparam int PER = 10;
    localparam int PUL = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0;
    logic to  = 1'b0;
    logic pg  = 1'b1;
    logic slp, hb, wk;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wsd_sleep_detect #(.MISS_LIMIT(LIM), .HB_PERIOD(PER), .HB_PULSE(PUL)) u0 (
        .clk(clk), .rst(rst), .clr_in(clr), .wd_timeout(to),
        .pwr_good(pg), .sleep_o(slp), .hb_rst_o(hb), .wake_o(wk)
    );

    task automatic chk(string tag, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic strobe();
        to = 1'b1; cyc(); to = 1'b0;
    endtask

    task automatic pcycle();
        pg = 1'b0; cyc(); pg = 1'b1; cyc(); cyc();
    endtask

    task automatic enter();
        pcycle();
        for (int i = 0; i < LIM; i++) begin strobe(); cyc(); end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        chk("R1 sleep in reset", slp, 1'b0);
        chk("R1 hb in reset", hb, 1'b0);
        chk("R1 wake in reset", wk, 1'b0);
        rst = 1'b0; cyc();
        chk("R1 sleep after reset", slp, 1'b0);
        chk("R1 wake after reset", wk, 1'b0);

        // R2: sweep the number of consecutive strobes
        for (int n = 0; n <= 5; n++) begin
            pcycle();
            for (int i = 0; i < n; i++) begin
                strobe();
                chk("R2 entry count", slp, (i + 1 >= LIM));
                cyc(); cyc();
                chk("R2 entry hold", slp, (i + 1 >= LIM));
            end
            chk("R2 final", slp, (n >= LIM));
        end

        // R4 heartbeat pattern, R10 strobes ignored while asleep
        pcycle();
        for (int i = 0; i < LIM - 1; i++) begin strobe(); cyc(); end
        strobe();
        for (int k = 0; k < 4 * PER; k++) begin
            chk("R4 hb pattern", hb, ((k % PER) >= PER - PUL));
            chk("R10 still asleep", slp, 1'b1);
            to = (k == 12 || k == 13);
            cyc();
        end
        to = 1'b0;

        // R5 rising change wakes
        clr = 1'b0; cyc();
        chk("R5 pre", slp, 1'b1);
        clr = 1'b1; cyc();
        chk("R5 rising wakes", slp, 1'b0);
        chk("R8 wake pulse rising", wk, 1'b1);
        chk("R4 hb awake", hb, 1'b0);
        cyc();
        chk("R8 wake one cycle", wk, 1'b0);

        // R6 falling change wakes
        enter();
        chk("R6 pre", slp, 1'b1);
        clr = 1'b0; cyc();
        chk("R6 falling wakes", slp, 1'b0);
        chk("R8 wake pulse falling", wk, 1'b1);
        cyc();
        chk("R8 wake one cycle falling", wk, 1'b0);

        // R7 power drop wakes and clears count
        enter();
        chk("R7 pre", slp, 1'b1);
        pg = 1'b0; cyc();
        chk("R7 power drop wakes", slp, 1'b0);
        chk("R8 wake on power drop", wk, 1'b1);
        for (int i = 0; i < LIM; i++) begin strobe(); cyc(); end
        chk("R7 strobes ignored low", slp, 1'b0);
        chk("R8 no second wake", wk, 1'b0);
        pg = 1'b1; cyc();
        for (int i = 0; i < LIM - 1; i++) begin strobe(); cyc(); end
        chk("R7 count restarted", slp, 1'b0);
        strobe();
        chk("R7 reenter", slp, 1'b1);

        // R3 change between strobes restarts count, R8 no wake while awake
        pcycle();
        for (int i = 0; i < LIM - 1; i++) begin strobe(); cyc(); end
        clr = ~clr; cyc();
        chk("R8 no wake when awake", wk, 1'b0);
        for (int i = 0; i < LIM - 1; i++) begin strobe(); cyc(); end
        chk("R3 count restarted", slp, 1'b0);
        strobe();
        chk("R3 enter after restart", slp, 1'b1);

        // R9 change and final strobe in the same cycle
        pcycle();
        for (int i = 0; i < LIM - 1; i++) begin strobe(); cyc(); end
        to = 1'b1; clr = ~clr; cyc(); to = 1'b0;
        chk("R9 change wins", slp, 1'b0);
        cyc();
        for (int i = 0; i < LIM - 1; i++) begin strobe(); cyc(); end
        chk("R9 count was zeroed", slp, 1'b0);
        strobe();
        chk("R9 enter afterwards", slp, 1'b1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule